// File: doc/BRIEF.md
# Branch and Jump Next-PC Unit

This block owns the program counter of a 16-bit, word-addressed RISC core and picks the next fetch address every clock. Each cycle it looks at the decoded 5-bit opcode of the instruction at the current PC. The next address is one of four choices:

- the sequential successor;
- a PC-relative branch target, when a comparison of the two register operands succeeds;
- an absolute target that stays inside the current 2K-word region;
- a full 16-bit address taken from a register.

For the two linking jumps it also raises a one-cycle request to write the return address into link register R7.

The surrounding pipeline supplies the opcode, the two operand values read from the register file, the 5-bit branch offset and the 11-bit jump target. It also drives a stall input that freezes the PC. Instruction memory, the register file and hazard detection sit outside this block.

Top module: `npc_unit`

## Requirements
- R1: A synchronous active-high `rst` sets `pc` to 0x0000 at the next rising edge. This applies whatever the other inputs are, including `stall`.
- R2: While `stall` is high (and `rst` low), `pc` keeps its value across the edge and `link_we` stays low.
- R3: Any opcode outside 10110 to 11101 advances `pc` by one, modulo 2^16, so 0xFFFF is followed by 0x0000.
- R4: Opcode 10110 (branch if equal) loads `pc + 1 + sext(br_off)` when `opnd_a == opnd_b`. Otherwise it loads `pc + 1`.
- R5: Opcode 10111 (branch if not equal) loads `pc + 1 + sext(br_off)` when `opnd_a != opnd_b`. Otherwise it loads `pc + 1`.
- R6: Opcode 11000 branches when `opnd_a`, read as two's complement, is greater than zero. Opcode 11001 branches when it is below zero. An operand of zero takes neither branch. The target and fall-through addresses are the same as in R4.
- R7: Opcodes 11010 (jump) and 11011 (jump and link) load `{pc[15:11], jmp_tgt}`.
- R8: Opcodes 11100 (jump register) and 11101 (jump and link register) load the full value of `opnd_a`.
- R9: `link_we` is high exactly in the cycles where opcode 11011 or 11101 is presented with `stall` low. In those cycles `link_data` equals `pc + 1` of that instruction.
- R10: `br_off` is sign-extended from bit 4, so 5'b10000 means -16 and 5'b01111 means +15. Target arithmetic wraps modulo 2^16.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| stall | input | 1 | Hold the PC for this cycle |
| opcode | input | 5 | Opcode of the instruction at `pc` |
| opnd_a | input | 16 | First register operand (compare source, indirect target) |
| opnd_b | input | 16 | Second register operand (compare source) |
| br_off | input | 5 | Signed branch offset |
| jmp_tgt | input | 11 | Region-relative jump target |
| pc | output | 16 | Current program counter |
| link_we | output | 1 | Request to write R7 |
| link_data | output | 16 | Return address for R7 |

## Verification
Some conditions are hard to reach with random stimulus:

- 16-bit counter wraparound;
- region jumps whose upper PC bits are nonzero;
- branch targets that cross 0x0000.

The bench therefore first uses jump-register to place the PC at 0xFFFF, 0xF800 and 0x0002. From each position it issues sequential steps, region jumps and maximum-negative offsets. Random operands almost never compare equal or land on exactly zero. For this reason the random phase copies `opnd_a` into `opnd_b` on half of the vectors and forces `opnd_a` to zero on a quarter of them, so both outcomes of every condition occur. A behavioural model in the bench predicts `pc`, `link_we` and `link_data` on every cycle.

// File: rtl/npc_pkg.sv
package npc_pkg;
   localparam int OPC_W = 5;

   typedef enum logic [OPC_W-1:0] {
      OP_BEQ  = 5'b10110,
      OP_BNE  = 5'b10111,
      OP_BGTZ = 5'b11000,
      OP_BLTZ = 5'b11001,
      OP_J    = 5'b11010,
      OP_JAL  = 5'b11011,
      OP_JR   = 5'b11100,
      OP_JALR = 5'b11101
   } ctl_op_e;

   typedef enum logic [1:0] {
      SEL_SEQ    = 2'd0,
      SEL_BRANCH = 2'd1,
      SEL_REGION = 2'd2,
      SEL_REG    = 2'd3
   } pc_sel_e;
endpackage

// File: rtl/npc_cond.sv
module npc_cond
   import npc_pkg::*;
#(
   parameter int  DATA_W     = 16,
   parameter bit  SIGNED_CMP = 1'b1
) (
   input  logic [OPC_W-1:0]  opcode,
   input  logic [DATA_W-1:0] opnd_a,
   input  logic [DATA_W-1:0] opnd_b,
   output logic              take
);
   logic eq_hit;
   logic pos_hit;
   logic neg_hit;

   assign eq_hit = (opnd_a == opnd_b);

   generate
      if (SIGNED_CMP) begin : g_signed
         assign neg_hit = opnd_a[DATA_W-1];
         assign pos_hit = !opnd_a[DATA_W-1] && (|opnd_a);
      end else begin : g_unsigned
         assign neg_hit = 1'b0;
         assign pos_hit = |opnd_a;
      end
   endgenerate

   always_comb begin
      case (opcode)
         OP_BEQ:  take = eq_hit;
         OP_BNE:  take = !eq_hit;
         OP_BGTZ: take = pos_hit;
         OP_BLTZ: take = neg_hit;
         default: take = 1'b0;
      endcase
   end
endmodule

// File: rtl/npc_decode.sv
module npc_decode
   import npc_pkg::*;
(
   input  logic [OPC_W-1:0] opcode,
   input  logic             take,
   output pc_sel_e          sel,
   output logic             link_req
);
   always_comb begin
      sel      = SEL_SEQ;
      link_req = 1'b0;
      case (opcode)
         OP_BEQ, OP_BNE, OP_BGTZ, OP_BLTZ:
            sel = take ? SEL_BRANCH : SEL_SEQ;
         OP_J:    sel = SEL_REGION;
         OP_JAL: begin
            sel      = SEL_REGION;
            link_req = 1'b1;
         end
         OP_JR:   sel = SEL_REG;
         OP_JALR: begin
            sel      = SEL_REG;
            link_req = 1'b1;
         end
         default: sel = SEL_SEQ;
      endcase
   end
endmodule

// File: rtl/npc_target.sv
module npc_target
   import npc_pkg::*;
#(
   parameter int PC_W  = 16,
   parameter int OFF_W = 5,
   parameter int TGT_W = 11
) (
   input  logic [PC_W-1:0]  pc,
   input  logic [PC_W-1:0]  reg_tgt,
   input  logic [OFF_W-1:0] br_off,
   input  logic [TGT_W-1:0] jmp_tgt,
   input  pc_sel_e          sel,
   output logic [PC_W-1:0]  seq_pc,
   output logic [PC_W-1:0]  next_pc
);
   localparam int REGION_W = PC_W - TGT_W;

   logic [PC_W-1:0] off_ext;
   logic [PC_W-1:0] region_pc;

   generate
      if (OFF_W < PC_W) begin : g_ext
         assign off_ext = {{(PC_W-OFF_W){br_off[OFF_W-1]}}, br_off};
      end else begin : g_trunc
         assign off_ext = br_off[PC_W-1:0];
      end
   endgenerate

   assign seq_pc    = pc + {{(PC_W-1){1'b0}}, 1'b1};
   assign region_pc = {pc[PC_W-1 -: REGION_W], jmp_tgt};

   always_comb begin
      case (sel)
         SEL_BRANCH: next_pc = seq_pc + off_ext;
         SEL_REGION: next_pc = region_pc;
         SEL_REG:    next_pc = reg_tgt;
         default:    next_pc = seq_pc;
      endcase
   end
endmodule

// File: rtl/npc_unit.sv
module npc_unit
   import npc_pkg::*;
#(
   parameter int PC_W       = 16,
   parameter int OFF_W      = 5,
   parameter int TGT_W      = 11,
   parameter bit SIGNED_CMP = 1'b1
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               stall,
   input  logic [OPC_W-1:0]   opcode,
   input  logic [PC_W-1:0]    opnd_a,
   input  logic [PC_W-1:0]    opnd_b,
   input  logic [OFF_W-1:0]   br_off,
   input  logic [TGT_W-1:0]   jmp_tgt,
   output logic [PC_W-1:0]    pc,
   output logic               link_we,
   output logic [PC_W-1:0]    link_data
);
   generate
      if (TGT_W >= PC_W) begin : g_bad_tgt
         $error("npc_unit: TGT_W must be narrower than PC_W");
      end
      if (OFF_W < 2) begin : g_bad_off
         $error("npc_unit: OFF_W must be at least 2");
      end
   endgenerate

   logic            take;
   logic            link_req;
   pc_sel_e         sel;
   logic [PC_W-1:0] seq_pc;
   logic [PC_W-1:0] next_pc;
   logic [PC_W-1:0] pc_q;

   npc_cond #(.DATA_W(PC_W), .SIGNED_CMP(SIGNED_CMP)) u_cond (
      .opcode (opcode),
      .opnd_a (opnd_a),
      .opnd_b (opnd_b),
      .take   (take)
   );

   npc_decode u_dec (
      .opcode   (opcode),
      .take     (take),
      .sel      (sel),
      .link_req (link_req)
   );

   npc_target #(.PC_W(PC_W), .OFF_W(OFF_W), .TGT_W(TGT_W)) u_tgt (
      .pc      (pc_q),
      .reg_tgt (opnd_a),
      .br_off  (br_off),
      .jmp_tgt (jmp_tgt),
      .sel     (sel),
      .seq_pc  (seq_pc),
      .next_pc (next_pc)
   );

   always_ff @(posedge clk) begin
      if (rst)         pc_q <= '0;
      else if (!stall) pc_q <= next_pc;
   end

   assign pc        = pc_q;
   assign link_we   = link_req && !stall && !rst;
   assign link_data = seq_pc;
endmodule

// File: rtl/npc_unit_chk.sv
module npc_unit_chk
   import npc_pkg::*;
#(
   parameter int PC_W  = 16,
   parameter int OFF_W = 5,
   parameter int TGT_W = 11
) (
   input logic               clk,
   input logic               rst,
   input logic               stall,
   input logic [OPC_W-1:0]   opcode,
   input logic [PC_W-1:0]    opnd_a,
   input logic [TGT_W-1:0]   jmp_tgt,
   input logic [PC_W-1:0]    pc,
   input logic               link_we,
   input logic [PC_W-1:0]    link_data
);
   logic is_ctl;
   assign is_ctl = (opcode >= 5'b10110) && (opcode <= 5'b11101);

   AST_RESET_CLEAR: assert property (@(posedge clk)
      rst |=> (pc == '0)); // R1

   AST_STALL_HOLD: assert property (@(posedge clk) disable iff (rst)
      stall |=> $stable(pc)); // R2

   AST_STALL_NO_LINK: assert property (@(posedge clk) disable iff (rst)
      stall |-> !link_we); // R2

   AST_SEQ_STEP: assert property (@(posedge clk) disable iff (rst)
      (!stall && !is_ctl) |=> (pc == $past(pc) + 1'b1)); // R3

   AST_REGION_KEEP: assert property (@(posedge clk) disable iff (rst)
      (!stall && (opcode == OP_J || opcode == OP_JAL))
      |=> (pc == {$past(pc[PC_W-1:TGT_W]), $past(jmp_tgt)})); // R7

   AST_REG_JUMP: assert property (@(posedge clk) disable iff (rst)
      (!stall && (opcode == OP_JR || opcode == OP_JALR))
      |=> (pc == $past(opnd_a))); // R8

   AST_LINK_DATA: assert property (@(posedge clk) disable iff (rst)
      link_we |-> (link_data == pc + 1'b1)); // R9

   AST_LINK_ONLY_CALLS: assert property (@(posedge clk) disable iff (rst)
      link_we |-> (opcode == OP_JAL || opcode == OP_JALR)); // R9
endmodule

bind npc_unit npc_unit_chk #(.PC_W(PC_W), .OFF_W(OFF_W), .TGT_W(TGT_W)) u_chk (
   .clk       (clk),
   .rst       (rst),
   .stall     (stall),
   .opcode    (opcode),
   .opnd_a    (opnd_a),
   .jmp_tgt   (jmp_tgt),
   .pc        (pc),
   .link_we   (link_we),
   .link_data (link_data)
);

// File: tb/npc_unit_bench.sv
module npc_unit_bench;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        stall = 1'b0;
   logic [4:0]  opcode = 5'd0;
   logic [15:0] opnd_a = '0;
   logic [15:0] opnd_b = '0;
   logic [4:0]  br_off = '0;
   logic [10:0] jmp_tgt = '0;
   logic [15:0] pc;
   logic        link_we;
   logic [15:0] link_data;

   int n_vec = 0;
   int n_bad = 0;
   int cyc = 0;
   int mpc = 0;
   logic [31:0] lfsr = 32'hACE1_2468;

   npc_unit u_npc_unit (
      .clk(clk), .rst(rst), .stall(stall), .opcode(opcode),
      .opnd_a(opnd_a), .opnd_b(opnd_b), .br_off(br_off), .jmp_tgt(jmp_tgt),
      .pc(pc), .link_we(link_we), .link_data(link_data)
   );

   always #10 clk = ~clk;

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc > 100000) begin
         n_bad = n_bad + 1;
         $display("FAIL watchdog: run hung, actual cycles %0d expected < 100000", cyc);
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

   task automatic chk(input string req, input string what, input int act, input int exp);
      n_vec = n_vec + 1;
      if (act != exp) begin
         n_bad = n_bad + 1;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   function automatic int sgn16(input int v);
      return (v >= 32768) ? v - 65536 : v;
   endfunction

   function automatic string tag_of(input int op, input bit st);
      if (st) return "R2";
      case (op)
         22: return "R4";
         23: return "R5";
         24, 25: return "R6";
         26, 27: return "R7";
         28, 29: return "R8";
         default: return "R3";
      endcase
   endfunction

   // Apply one vector: inputs driven after a falling edge, model advanced at the rising edge.
   task automatic step(input int op, input int a, input int b, input int off,
                       input int tgt, input bit st, input bit rs, input string req);
      int  nxt;
      int  offv;
      bit  tk;
      bit  lk;
      chk(req, "pc before step", int'(pc), mpc);
      opcode = op[4:0]; opnd_a = a[15:0]; opnd_b = b[15:0];
      br_off = off[4:0]; jmp_tgt = tgt[10:0]; stall = st; rst = rs;
      #1;
      offv = (off >= 16) ? off - 32 : off;   // R10 sign extension
      lk = !rs && !st && (op == 27 || op == 29);
      chk(lk ? "R9" : req, "link_we", int'(link_we), int'(lk));
      if (lk) chk("R9", "link_data", int'(link_data), (mpc + 1) % 65536);
      tk = 1'b0;
      case (op)
         22: tk = (a == b);
         23: tk = (a != b);
         24: tk = (sgn16(a) > 0);
         25: tk = (sgn16(a) < 0);
         default: tk = 1'b0;
      endcase
      if (rs)                    nxt = 0;
      else if (st)               nxt = mpc;
      else if (op >= 22 && op <= 25)
         nxt = tk ? (mpc + 1 + offv + 65536) % 65536 : (mpc + 1) % 65536;
      else if (op == 26 || op == 27) nxt = (mpc & 16'hF800) | tgt;
      else if (op == 28 || op == 29) nxt = a;
      else                       nxt = (mpc + 1) % 65536;
      @(posedge clk);
      mpc = nxt;
      @(negedge clk);
   endtask

   initial begin
      @(negedge clk);
      @(negedge clk);
      mpc = 0;
      // R1: reset state
      chk("R1", "pc after reset", int'(pc), 0);
      chk("R1", "link_we in reset", int'(link_we), 0);
      step(0, 0, 0, 0, 0, 0, 1, "R1");
      // R3: sequential
      step(1, 0, 0, 0, 0, 0, 0, "R3");
      step(5, 0, 0, 0, 0, 0, 0, "R3");
      step(31, 0, 0, 0, 0, 0, 0, "R3");
      // R4 taken / not taken
      step(22, 16'h1234, 16'h1234, 5, 0, 0, 0, "R4");
      step(22, 16'h1234, 16'h1235, 5, 0, 0, 0, "R4");
      // R5
      step(23, 7, 8, 3, 0, 0, 0, "R5");
      step(23, 9, 9, 3, 0, 0, 0, "R5");
      // R6 signed compare, zero takes neither
      step(24, 1, 0, 2, 0, 0, 0, "R6");
      step(24, 16'h8000, 0, 2, 0, 0, 0, "R6");
      step(24, 0, 0, 2, 0, 0, 0, "R6");
      step(25, 16'hFFFF, 0, 1, 0, 0, 0, "R6");
      step(25, 0, 0, 1, 0, 0, 0, "R6");
      step(25, 16'h7FFF, 0, 1, 0, 0, 0, "R6");
      // R2 stall, including stalled JAL
      step(27, 0, 0, 0, 11'h155, 1, 0, "R2");
      step(26, 0, 0, 0, 11'h7FF, 1, 0, "R2");
      // R8 / R3 wrap
      step(28, 16'hFFFF, 0, 0, 0, 0, 0, "R8");
      step(0, 0, 0, 0, 0, 0, 0, "R3");
      step(0, 0, 0, 0, 0, 0, 0, "R3");
      // R7 region jumps with nonzero upper bits
      step(28, 16'hF800, 0, 0, 0, 0, 0, "R8");
      step(26, 0, 0, 0, 11'h2A5, 0, 0, "R7");
      step(27, 0, 0, 0, 11'h7FF, 0, 0, "R7");
      // R10 max negative offset crossing zero
      step(29, 16'h0002, 0, 0, 0, 0, 0, "R8");
      step(22, 4, 4, 16, 0, 0, 0, "R10");
      step(23, 4, 5, 15, 0, 0, 0, "R10");
      // reset with stall high
      step(0, 0, 0, 0, 0, 1, 1, "R1");
      // random phase
      for (int i = 0; i < 400; i++) begin
         int op, a, b, off, tgt;
         bit st;
         lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
         lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
         lfsr = lfsr * 32'd1664525 + 32'd1013904223;
         op  = (lfsr[3]) ? 22 + int'(lfsr[6:4]) : int'(lfsr[4:0]);
         a   = int'(lfsr[31:16]);
         if (lfsr[9:8] == 2'b00) a = 0;
         b   = lfsr[10] ? a : int'({lfsr[15:0]});
         off = int'(lfsr[15:11]);
         tgt = int'(lfsr[26:16]);
         st  = (lfsr[14:12] == 3'b000);
         step(op, a, b, off, tgt, st, 0, tag_of(op, st));
      end
      chk("R3", "final pc", int'(pc), mpc);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end
endmodule